// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This controller sits between a host memory port and a battery-backed 8K x 8 static RAM. Three comparator flags report the supply level: below the upper deselect threshold, below the lower deselect threshold, and below the battery switchover level. The flags pass through a synchronizer and a glitch filter and then drive a four-state machine. That machine gates the RAM chip-enable, write-enable and output-enable, releases or floats the data bus, and selects the battery.

Protection is asymmetric. On a falling supply the RAM is cut off at once. On a rising supply it stays locked for a timed recovery window. When the supply drops straight through the deselect window within one filter resolution (a fast fall), both low flags are seen together. In that case reads may keep running for a configurable worst-case delay, but writes are refused at once.

States, numbered in the status output:

- NORMAL (0): host access passes through.
- PROTECT (1): deselected.
- BATTERY (2): deselected, with the battery powering the array.
- RECOVER (3): deselected while the recovery counter runs.

Transitions:

- NORMAL to PROTECT when either deselect flag rises.
- NORMAL to BATTERY when the switchover flag rises.
- PROTECT to RECOVER when both deselect flags clear.
- BATTERY to PROTECT when the switchover flag clears.
- RECOVER to NORMAL when the count expires.
- RECOVER back to PROTECT or BATTERY if the supply dips again.
- Any state except BATTERY goes to BATTERY as soon as the switchover flag is set.

Top module: `pfw_seq`

## Requirements
- R1: `state_o` encodes NORMAL=0, PROTECT=1, BATTERY=2, RECOVER=3, and reset leaves the block in PROTECT.
- R2: A raw supply flag changes the filtered level only after FILT_CYC consecutive synchronized cycles. A pulse of FILT_CYC-1 cycles has no effect. A lasting change moves `state_o` within FILT_CYC+2 to FILT_CYC+4 cycles.
- R3: In NORMAL the host modes decode as follows:
  - Enable high: deselect, with every RAM strobe inactive.
  - Enable low and write low: write, with `ram_we_n_o`=0 and `ram_wdata_o` equal to the host data.
  - Enable low, write high and output-enable low: read, with `ram_oe_n_o`=0 and `bus_drive_o`=1.
  - Enable low, write high and output-enable high: outputs off.
  - The address is passed only while selected; otherwise `ram_addr_o`, and `ram_wdata_o` outside a write, are 0.
- R4: When the upper deselect flag rises alone, NORMAL moves to PROTECT. In PROTECT all RAM strobes are high, `bus_drive_o` is 0, the address and data outputs are 0, and every host input is ignored.
- R5: `ram_we_n_o` is low only in NORMAL. Below the lower threshold no write ever reaches the RAM.
- R6: A write strobe active when protection engages is cut in the same cycle that `state_o` leaves NORMAL.
- R7: The switchover flag moves any state to BATTERY. There `batt_sel_o`=1 and the RAM is deselected. When the flag clears, the block moves to PROTECT with `batt_sel_o`=0, and `batt_sel_o` is 1 in no other state.
- R8: Once both deselect flags clear, RECOVER lasts exactly REC_CYC cycles and then becomes NORMAL. A flag rising during RECOVER leaves it, and the next recovery restarts the full count.
- R9: Both deselect flags seen in the same NORMAL cycle (fast fall) enter PROTECT with chip-enable and reads still passed for exactly DEFER_CYC cycles, while writes are blocked.
- R10: A host write strobe that is still low when protection releases is ignored until it has gone high and low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_below_hi_i | input | 1 | Supply below upper deselect threshold |
| sup_below_lo_i | input | 1 | Supply below lower deselect threshold |
| sup_below_so_i | input | 1 | Supply below battery switchover level |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| host_addr_i | input | ADDR_W | Host address |
| host_wdata_i | input | DATA_W | Host write data |
| ram_ce_n_o | output | 1 | Gated RAM chip enable |
| ram_we_n_o | output | 1 | Gated RAM write enable |
| ram_oe_n_o | output | 1 | Gated RAM output enable |
| ram_addr_o | output | ADDR_W | Gated RAM address |
| ram_wdata_o | output | DATA_W | Gated RAM write data |
| bus_drive_o | output | 1 | Read data may drive the host bus; 0 means high impedance |
| batt_sel_o | output | 1 | Array powered from battery |
| state_o | output | 2 | Current state code |

## Verification
The bench builds the block with FILT_CYC=3, REC_CYC=150 and DEFER_CYC=40. These small values let the run cover several complete recovery windows in a few thousand cycles, including one that is interrupted and restarted. They also let the bench count the fast-fall read window cycle by cycle. A filter of three cycles lets a two-cycle glitch be shown as rejected, while the filter still adds enough latency that the synchronizer-to-state delay is measured and not assumed.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_PROTECT = 2'd1,
        ST_BATTERY = 2'd2,
        ST_RECOVER = 2'd3
    } pfw_state_e;

    localparam int NUM_FLAGS = 3;
    localparam int FLG_HI = 0;
    localparam int FLG_LO = 1;
    localparam int FLG_SO = 2;
endpackage

// File: rtl/pfw_flag_filter.sv
module pfw_flag_filter #(
    parameter int   FILT_CYC = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          s1, s2;
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= RST_VAL;
            s2    <= RST_VAL;
            flt_o <= RST_VAL;
            run   <= '0;
        end else begin
            s1 <= raw_i;
            s2 <= s1;
            if (s2 == flt_o) begin
                run <= '0;
            end else if (run == CW'(FILT_CYC - 1)) begin
                flt_o <= s2;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfw_fsm.sv
module pfw_fsm
    import pfw_pkg::*;
#(
    parameter int REC_CYC   = 100000,
    parameter int DEFER_CYC = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       f_hi,
    input  logic       f_lo,
    input  logic       f_so,
    output pfw_state_e st,
    output logic       defer_act
);
    localparam int RW = $clog2(REC_CYC + 1);
    localparam int DW = $clog2(DEFER_CYC + 2);

    pfw_state_e    nxt;
    logic          ld_rec, ld_fast;
    logic [RW-1:0] rec_cnt;
    logic [DW-1:0] dly_cnt;

    // next-state decode
    always_comb begin
        nxt     = st;
        ld_rec  = 1'b0;
        ld_fast = 1'b0;
        unique case (st)
            ST_NORMAL: begin
                if (f_so) begin
                    nxt = ST_BATTERY;
                end else if (f_hi || f_lo) begin
                    nxt     = ST_PROTECT;
                    ld_fast = f_lo;
                end
            end
            ST_PROTECT: begin
                if (f_so) begin
                    nxt = ST_BATTERY;
                end else if (!f_hi && !f_lo) begin
                    nxt    = ST_RECOVER;
                    ld_rec = 1'b1;
                end
            end
            ST_BATTERY: begin
                if (!f_so) nxt = ST_PROTECT;
            end
            ST_RECOVER: begin
                if (f_so)                nxt = ST_BATTERY;
                else if (f_hi || f_lo)   nxt = ST_PROTECT;
                else if (rec_cnt == '0)  nxt = ST_NORMAL;
            end
            default: nxt = ST_PROTECT;
        endcase
    end

    // state register and timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_PROTECT;
            rec_cnt <= '0;
            dly_cnt <= '0;
        end else begin
            st <= nxt;
            if (ld_rec)
                rec_cnt <= RW'(REC_CYC - 1);
            else if (st == ST_RECOVER && rec_cnt != '0)
                rec_cnt <= rec_cnt - 1'b1;
            if (ld_fast)
                dly_cnt <= DW'(DEFER_CYC);
            else if (nxt == ST_PROTECT && dly_cnt != '0)
                dly_cnt <= dly_cnt - 1'b1;
            else
                dly_cnt <= '0;
        end
    end

    // outputs
    always_comb begin
        defer_act = (st == ST_PROTECT) && (dly_cnt != '0);
    end
endmodule

// File: rtl/pfw_gate.sv
module pfw_gate
    import pfw_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pfw_state_e        st,
    input  logic              defer_act,
    input  logic              host_ce_n,
    input  logic              host_we_n,
    input  logic              host_oe_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              bus_drive
);
    logic armed, sel, wr, rd, is_norm;

    // write re-arm: a strobe low across a release is not honoured
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (st == ST_NORMAL)
            armed <= armed | host_we_n;
        else
            armed <= host_we_n;
    end

    always_comb begin
        is_norm   = (st == ST_NORMAL);
        sel       = (is_norm || defer_act) && !host_ce_n;
        wr        = sel && is_norm && armed && !host_we_n;
        rd        = sel && host_we_n && !host_oe_n;
        ram_ce_n  = !sel;
        ram_we_n  = !wr;
        ram_oe_n  = !rd;
        bus_drive = rd;
        ram_addr  = sel ? host_addr : '0;
        ram_wdata = wr ? host_wdata : '0;
    end
endmodule

// File: rtl/pfw_seq.sv
module pfw_seq
    import pfw_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int FILT_CYC  = 4,
    parameter int REC_CYC   = 100000,
    parameter int DEFER_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_below_hi_i,
    input  logic              sup_below_lo_i,
    input  logic              sup_below_so_i,
    input  logic              host_ce_n_i,
    input  logic              host_we_n_i,
    input  logic              host_oe_n_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              ram_ce_n_o,
    output logic              ram_we_n_o,
    output logic              ram_oe_n_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              bus_drive_o,
    output logic              batt_sel_o,
    output logic [1:0]        state_o
);
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 3'b011;

    logic [NUM_FLAGS-1:0] raw, flt;
    pfw_state_e           st;
    logic                 defer_act;

    assign raw = {sup_below_so_i, sup_below_lo_i, sup_below_hi_i};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flt
        pfw_flag_filter #(
            .FILT_CYC(FILT_CYC),
            .RST_VAL (FLAG_RST[g])
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(raw[g]),
            .flt_o(flt[g])
        );
    end

    pfw_fsm #(
        .REC_CYC  (REC_CYC),
        .DEFER_CYC(DEFER_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .f_hi     (flt[FLG_HI]),
        .f_lo     (flt[FLG_LO]),
        .f_so     (flt[FLG_SO]),
        .st       (st),
        .defer_act(defer_act)
    );

    pfw_gate #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st),
        .defer_act (defer_act),
        .host_ce_n (host_ce_n_i),
        .host_we_n (host_we_n_i),
        .host_oe_n (host_oe_n_i),
        .host_addr (host_addr_i),
        .host_wdata(host_wdata_i),
        .ram_ce_n  (ram_ce_n_o),
        .ram_we_n  (ram_we_n_o),
        .ram_oe_n  (ram_oe_n_o),
        .ram_addr  (ram_addr_o),
        .ram_wdata (ram_wdata_o),
        .bus_drive (bus_drive_o)
    );

    assign batt_sel_o = (st == ST_BATTERY);
    assign state_o    = st;
endmodule

// File: rtl/pfw_seq_chk.sv
module pfw_seq_chk #(
    parameter int REC_CYC   = 100000,
    parameter int DEFER_CYC = 20000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_we_n_i,
    input logic       ram_ce_n_o,
    input logic       ram_we_n_o,
    input logic       ram_oe_n_o,
    input logic       bus_drive_o,
    input logic       batt_sel_o,
    input logic [1:0] state_o
);
    logic [31:0] rec_run, sel_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_run <= '0;
            sel_run <= '0;
        end else begin
            rec_run <= (state_o == 2'd3) ? rec_run + 1 : '0;
            sel_run <= (state_o == 2'd1 && !ram_ce_n_o) ? sel_run + 1 : '0;
        end
    end

    p_wr_only_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n_o |-> (state_o == 2'd0));

    p_batt_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel_o |-> (ram_ce_n_o && ram_we_n_o && !bus_drive_o && state_o == 2'd2));

    p_drive_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_o |-> (!ram_ce_n_o && !ram_oe_n_o && ram_we_n_o));

    p_cut_on_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0 && $past(state_o) == 2'd0) |-> ram_we_n_o);

    p_rec_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && $past(state_o) == 2'd3) |-> (rec_run == REC_CYC));

    p_defer_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_run <= DEFER_CYC);

    p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && $past(state_o) != 2'd0 && !host_we_n_i && !$past(host_we_n_i))
        |-> ram_we_n_o);
endmodule

bind pfw_seq pfw_seq_chk #(
    .REC_CYC  (REC_CYC),
    .DEFER_CYC(DEFER_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we_n_i(host_we_n_i),
    .ram_ce_n_o (ram_ce_n_o),
    .ram_we_n_o (ram_we_n_o),
    .ram_oe_n_o (ram_oe_n_o),
    .bus_drive_o(bus_drive_o),
    .batt_sel_o (batt_sel_o),
    .state_o    (state_o)
);

// File: tb/tb_pfw_seq.sv
`timescale 1ns/1ps
module tb_pfw_seq;
    localparam int AW = 13;
    localparam int DW = 8;
    localparam int FILT = 3;
    localparam int REC = 150;
    localparam int DEFER = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b0, so = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic r_ce_n, r_we_n, r_oe_n, drv, batt;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_wdata;
    logic [1:0] st;
    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pfw_seq #(.ADDR_W(AW), .DATA_W(DW), .FILT_CYC(FILT), .REC_CYC(REC), .DEFER_CYC(DEFER)) dut (
        .clk(clk), .rst_n(rst_n),
        .sup_below_hi_i(hi), .sup_below_lo_i(lo), .sup_below_so_i(so),
        .host_ce_n_i(ce_n), .host_we_n_i(we_n), .host_oe_n_i(oe_n),
        .host_addr_i(addr), .host_wdata_i(wdata),
        .ram_ce_n_o(r_ce_n), .ram_we_n_o(r_we_n), .ram_oe_n_o(r_oe_n),
        .ram_addr_o(r_addr), .ram_wdata_o(r_wdata),
        .bus_drive_o(drv), .batt_sel_o(batt), .state_o(st)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo_b, input int hi_b);
        tests++;
        if (act < lo_b || act > hi_b) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo_b, hi_b);
        end
    endtask

    // expected {ce_n, we_n, oe_n, drive} for a fully armed host in NORMAL or a non-deferred state
    function automatic logic [3:0] exp_ctl(input logic [1:0] s, input logic c, input logic w, input logic o);
        logic sel, wr, rd;
        sel = (s == 2'd0) && !c;
        wr  = sel && !w;
        rd  = sel && w && !o;
        return {!sel, !wr, !rd, rd};
    endfunction

    task automatic wait_st(input logic [1:0] s, output int n);
        n = 0;
        while (st != s && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic count_st(input logic [1:0] s, output int n);
        n = 0;
        while (st == s && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic rand_host();
        ce_n  = 1'($urandom_range(0, 1));
        we_n  = 1'($urandom_range(0, 1));
        oe_n  = 1'($urandom_range(0, 1));
        addr  = AW'($urandom);
        wdata = DW'($urandom);
    endtask

    task automatic check_quiet(input string req);
        chk(req, {r_ce_n, r_we_n, r_oe_n, drv}, 4'b1110);
        chk(req, {19'd0, r_addr}, 32'd0);
        chk(req, {24'd0, r_wdata}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [3:0] e;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        #1;
        chk("R1 reset state PROTECT", {30'd0, st}, 32'd1);
        check_quiet("R4 reset deselected");
        chk("R7 reset batt off", {31'd0, batt}, 32'd0);
        rst_n = 1'b1;

        // power-up: flags clear, then full recovery
        wait_st(2'd3, n);
        chk_rng("R2 flag latency after reset", n, FILT + 2, FILT + 4);
        count_st(2'd3, n);
        chk("R8 recovery length", n, REC);
        chk("R1 NORMAL code", {30'd0, st}, 32'd0);

        // random host traffic in NORMAL
        we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            rand_host();
            #1;
            e = exp_ctl(st, ce_n, we_n, oe_n);
            chk("R3 strobes", {28'd0, r_ce_n, r_we_n, r_oe_n, drv}, {28'd0, e});
            chk("R3 address", {19'd0, r_addr}, {19'd0, (!ce_n ? addr : 13'd0)});
            chk("R3 write data", {24'd0, r_wdata}, {24'd0, (!ce_n && !we_n) ? wdata : 8'd0});
        end

        // glitch shorter than the filter
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        hi = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        hi = 1'b0;
        n = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (st != 2'd0) n++;
        end
        chk("R2 short glitch ignored", n, 0);

        // slow fall with a write in progress
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 13'h0A5; wdata = 8'h3C;
        @(negedge clk);
        #1;
        chk("R3 write before fall", {31'd0, r_we_n}, 32'd0);
        hi = 1'b1;
        wait_st(2'd1, n);
        chk_rng("R2 fall latency", n, FILT + 2, FILT + 4);
        chk("R6 write cut on protect", {31'd0, r_we_n}, 32'd1);
        chk("R4 deselect on upper flag", {31'd0, r_ce_n}, 32'd1);

        // inputs ignored in PROTECT
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rand_host();
            #1;
            check_quiet("R4 inputs ignored");
        end
        lo = 1'b1;
        repeat (20) @(negedge clk);
        chk("R5 below lower stays PROTECT", {30'd0, st}, 32'd1);
        ce_n = 1'b0; we_n = 1'b0;
        #1;
        chk("R5 write blocked below lower", {31'd0, r_we_n}, 32'd1);

        // battery switchover
        so = 1'b1;
        wait_st(2'd2, n);
        chk("R7 enters BATTERY", {30'd0, st}, 32'd2);
        chk("R7 batt_sel", {31'd0, batt}, 32'd1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rand_host();
            #1;
            check_quiet("R7 battery deselect");
        end
        so = 1'b0;
        wait_st(2'd1, n);
        chk("R7 back to PROTECT", {30'd0, st}, 32'd1);
        chk("R7 batt released", {31'd0, batt}, 32'd0);

        // interrupted recovery with the write strobe held low
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        hi = 1'b0; lo = 1'b0;
        wait_st(2'd3, n);
        repeat (30) @(negedge clk);
        #1;
        chk("R5 write blocked in RECOVER", {31'd0, r_we_n}, 32'd1);
        hi = 1'b1;
        wait_st(2'd1, n);
        chk("R8 dip in RECOVER returns to PROTECT", {30'd0, st}, 32'd1);
        hi = 1'b0;
        wait_st(2'd3, n);
        count_st(2'd3, n);
        chk("R8 full restart of recovery", n, REC);

        // release with strobe still low
        for (int i = 0; i < 5; i++) begin
            #1;
            chk("R10 stale strobe ignored", {31'd0, r_we_n}, 32'd1);
            @(negedge clk);
        end
        we_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0; addr = 13'h1F0; wdata = 8'hC3;
        #1;
        chk("R10 fresh strobe honoured", {31'd0, r_we_n}, 32'd0);
        chk("R3 write address", {19'd0, r_addr}, 32'h1F0);
        chk("R3 write data pass", {24'd0, r_wdata}, 32'hC3);

        // fast fall during a read
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        hi = 1'b1; lo = 1'b1;
        wait_st(2'd1, n);
        n = 0;
        while (st == 2'd1 && r_ce_n == 1'b0 && n < 500) begin
            n++;
            if (n == 3) begin
                we_n = 1'b0;
                #1;
                chk("R9 write blocked in defer", {31'd0, r_we_n}, 32'd1);
                chk("R9 read off during write try", {31'd0, r_oe_n}, 32'd1);
            end else begin
                we_n = 1'b1;
            end
            @(negedge clk);
        end
        chk("R9 defer window length", n, DEFER);
        #1;
        chk("R9 deselect after defer", {31'd0, drv}, 32'd0);

        hi = 1'b0; lo = 1'b0; ce_n = 1'b1;
        wait_st(2'd0, n);
        chk("R1 back to NORMAL", {30'd0, st}, 32'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule